// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block sits in the execute stage of a five-stage in-order pipeline. It is purely combinational. It takes the two source register indices of the instruction now in execute, along with the operand values read for them from the register file. It compares each index with the destination index and register-write enable of the two younger results that have not yet committed. One of those results sits in the execute/memory boundary register. The other sits in the memory/writeback boundary register.

When a source names a register that one of those stages is about to write, the stale register-file value is replaced with the live result. If both stages match, the execute/memory stage holds the more recent write, so its value wins. The value taken from the memory/writeback stage is the full write-back result, selected by that stage's two-bit write-back selector. It is not just the ALU result, so forwarding from a load or from a link write also returns the correct data. The forwarded second operand is also driven out as the store data for the execute/memory register.

For each operand the block reports a two-bit select code, so that the operand multiplexers and any monitoring logic can see which path was taken. Load-use stalls are handled elsewhere.

Top module: `operand_bypass`

## Requirements
- R1: When neither younger stage matches a source, that operand's select code is 00 and its value equals the register-file value.
- R2: A source matches the execute/memory stage when em_we is 1, em_rd_idx is nonzero and em_rd_idx equals the source index. The select code is then 10 and the operand equals em_alu_res.
- R3: When only the memory/writeback stage matches a source, the select code is 01 and the operand equals the write-back value. Matching at that stage requires mw_we = 1, a nonzero mw_rd_idx, and mw_rd_idx equal to the source index.
- R4: When both stages match the same source, the select code is 10 and the operand equals em_alu_res.
- R5: A source index of 0 is never forwarded: its select code is 00 and its value is the register-file value, even when a stage writes register 0 with its enable set.
- R6: A stage whose write enable is 0 is never forwarded from, even when its destination index equals the source index.
- R7: The write-back value follows mw_wb_sel: 00 gives mw_alu_res, 01 gives mw_load_data, 11 gives mw_link_addr, and 10 gives zero.
- R8: store_data always equals the forwarded second operand op_b.
- R9: The two operands are resolved independently: each takes its own select code and value from its own index and register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_idx | input | 5 | First source register index in execute |
| ex_rs2_idx | input | 5 | Second source register index in execute |
| ex_rf_a | input | 32 | Register-file value read for the first source |
| ex_rf_b | input | 32 | Register-file value read for the second source |
| em_rd_idx | input | 5 | Destination index held in execute/memory |
| em_we | input | 1 | Register-write enable held in execute/memory |
| em_alu_res | input | 32 | ALU result held in execute/memory |
| mw_rd_idx | input | 5 | Destination index held in memory/writeback |
| mw_we | input | 1 | Register-write enable held in memory/writeback |
| mw_wb_sel | input | 2 | Write-back selector held in memory/writeback |
| mw_alu_res | input | 32 | ALU result held in memory/writeback |
| mw_load_data | input | 32 | Aligned load data held in memory/writeback |
| mw_link_addr | input | 32 | Return address (PC+4) held in memory/writeback |
| sel_a | output | 2 | Select code for the first operand |
| sel_b | output | 2 | Select code for the second operand |
| op_a | output | 32 | Forwarded first operand |
| op_b | output | 32 | Forwarded second operand |
| store_data | output | 32 | Store data, equal to the forwarded second operand |

## Verification
Every result of this block depends only on the current inputs. Each select code, operand and store value is therefore due in the same cycle as the stimulus, with no register in the path. The bench changes the inputs just after a rising edge and samples all outputs at the following falling edge, half a period later, when the logic has settled. It never reads an output in the cycle before or after the one in which it drove the inputs.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_RF  = 2'b00,
    SRC_MW  = 2'b01,
    SRC_EM  = 2'b10,
    SRC_BAD = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'b00,
    WB_LOAD = 2'b01,
    WB_NONE = 2'b10,
    WB_LINK = 2'b11
  } wb_sel_e;

  // The younger result (execute/memory) has priority over the older one.
  function automatic src_sel_e pick_source(input logic em_hit, input logic mw_hit);
    if (em_hit)      return SRC_EM;
    else if (mw_hit) return SRC_MW;
    else             return SRC_RF;
  endfunction

endpackage

// File: rtl/fwd_wb_select.sv
module fwd_wb_select #(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      wb_sel,
  input  logic [XLEN-1:0] alu_res,
  input  logic [XLEN-1:0] load_data,
  input  logic [XLEN-1:0] link_addr,
  output logic [XLEN-1:0] wb_value
);
  import fwd_pkg::*;

  always_comb begin
    unique case (wb_sel_e'(wb_sel))
      WB_ALU:  wb_value = alu_res;
      WB_LOAD: wb_value = load_data;
      WB_LINK: wb_value = link_addr;
      default: wb_value = '0;
    endcase
  end
endmodule

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src_idx,
  input  logic [AW-1:0] dst_idx,
  input  logic          dst_we,
  output logic          hit
);
  logic dst_nonzero;

  assign dst_nonzero = |dst_idx;
  assign hit         = dst_we & dst_nonzero & (src_idx == dst_idx);
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
  parameter int unsigned XLEN = 32
) (
  input  logic            em_hit,
  input  logic            mw_hit,
  input  logic [XLEN-1:0] rf_value,
  input  logic [XLEN-1:0] em_value,
  input  logic [XLEN-1:0] mw_value,
  output logic [1:0]      sel,
  output logic [XLEN-1:0] value
);
  import fwd_pkg::*;

  src_sel_e code;

  assign code = pick_source(em_hit, mw_hit);
  assign sel  = code;

  always_comb begin
    unique case (code)
      SRC_EM:  value = em_value;
      SRC_MW:  value = mw_value;
      default: value = rf_value;
    endcase
  end
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_rs1_idx,
  input  logic [REG_AW-1:0] ex_rs2_idx,
  input  logic [XLEN-1:0]   ex_rf_a,
  input  logic [XLEN-1:0]   ex_rf_b,
  input  logic [REG_AW-1:0] em_rd_idx,
  input  logic              em_we,
  input  logic [XLEN-1:0]   em_alu_res,
  input  logic [REG_AW-1:0] mw_rd_idx,
  input  logic              mw_we,
  input  logic [1:0]        mw_wb_sel,
  input  logic [XLEN-1:0]   mw_alu_res,
  input  logic [XLEN-1:0]   mw_load_data,
  input  logic [XLEN-1:0]   mw_link_addr,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [XLEN-1:0]   op_a,
  output logic [XLEN-1:0]   op_b,
  output logic [XLEN-1:0]   store_data
);
  localparam int unsigned NSRC = 2;

  logic [XLEN-1:0]   mw_value;
  logic [NSRC-1:0]   em_hit;
  logic [NSRC-1:0]   mw_hit;
  logic [REG_AW-1:0] src_idx  [NSRC];
  logic [XLEN-1:0]   rf_val   [NSRC];
  logic [XLEN-1:0]   fwd_val  [NSRC];
  logic [1:0]        fwd_sel  [NSRC];

  assign src_idx[0] = ex_rs1_idx;
  assign src_idx[1] = ex_rs2_idx;
  assign rf_val[0]  = ex_rf_a;
  assign rf_val[1]  = ex_rf_b;

  fwd_wb_select #(.XLEN(XLEN)) u_wb (
    .wb_sel    (mw_wb_sel),
    .alu_res   (mw_alu_res),
    .load_data (mw_load_data),
    .link_addr (mw_link_addr),
    .wb_value  (mw_value)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    fwd_hit_detect #(.AW(REG_AW)) u_em_hit (
      .src_idx (src_idx[s]),
      .dst_idx (em_rd_idx),
      .dst_we  (em_we),
      .hit     (em_hit[s])
    );
    fwd_hit_detect #(.AW(REG_AW)) u_mw_hit (
      .src_idx (src_idx[s]),
      .dst_idx (mw_rd_idx),
      .dst_we  (mw_we),
      .hit     (mw_hit[s])
    );
    fwd_operand_mux #(.XLEN(XLEN)) u_mux (
      .em_hit   (em_hit[s]),
      .mw_hit   (mw_hit[s]),
      .rf_value (rf_val[s]),
      .em_value (em_alu_res),
      .mw_value (mw_value),
      .sel      (fwd_sel[s]),
      .value    (fwd_val[s])
    );
  end

  assign sel_a      = fwd_sel[0];
  assign sel_b      = fwd_sel[1];
  assign op_a       = fwd_val[0];
  assign op_b       = fwd_val[1];
  assign store_data = fwd_val[1];
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_rs1_idx,
  input logic [REG_AW-1:0] ex_rs2_idx,
  input logic [XLEN-1:0]   ex_rf_a,
  input logic [XLEN-1:0]   em_alu_res,
  input logic [REG_AW-1:0] em_rd_idx,
  input logic              em_we,
  input logic [1:0]        mw_wb_sel,
  input logic [XLEN-1:0]   mw_value,
  input logic [1:0]        em_hit,
  input logic [1:0]        mw_hit,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [XLEN-1:0]   op_a,
  input logic [XLEN-1:0]   op_b,
  input logic [XLEN-1:0]   store_data
);
  always_comb begin
    // R1
    sel_code_legal_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
    // R8
    store_matches_b_chk: assert (store_data == op_b);
    // R5
    zero_src_a_chk: assert (ex_rs1_idx != '0 || (sel_a == 2'b00 && op_a == ex_rf_a));
    // R5
    zero_src_b_chk: assert (ex_rs2_idx != '0 || sel_b == 2'b00);
    // R4
    em_priority_chk: assert (!em_hit[0] || (sel_a == 2'b10 && op_a == em_alu_res));
    // R3
    mw_path_chk: assert (!(mw_hit[0] && !em_hit[0]) || (sel_a == 2'b01 && op_a == mw_value));
    // R6
    em_enable_chk: assert (em_we || sel_b != 2'b10);
    // R2
    em_index_chk: assert (sel_a != 2'b10 || ex_rs1_idx == em_rd_idx);
    // R7
    wb_unused_zero_chk: assert (mw_wb_sel != 2'b10 || mw_value == '0);
  end
endmodule

bind operand_bypass operand_bypass_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .ex_rs1_idx (ex_rs1_idx),
  .ex_rs2_idx (ex_rs2_idx),
  .ex_rf_a    (ex_rf_a),
  .em_alu_res (em_alu_res),
  .em_rd_idx  (em_rd_idx),
  .em_we      (em_we),
  .mw_wb_sel  (mw_wb_sel),
  .mw_value   (mw_value),
  .em_hit     (em_hit),
  .mw_hit     (mw_hit),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .op_a       (op_a),
  .op_b       (op_b),
  .store_data (store_data)
);

// File: tb/sim_operand_bypass.sv
`timescale 1ns/1ps
module sim_operand_bypass;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  rs1, rs2, em_rd, mw_rd;
  logic        em_we, mw_we;
  logic [1:0]  wbs;
  logic [31:0] rfa, rfb, em_alu, mw_alu, mw_ld, mw_lk;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] op_a, op_b, st;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  operand_bypass u0 (
    .ex_rs1_idx(rs1), .ex_rs2_idx(rs2), .ex_rf_a(rfa), .ex_rf_b(rfb),
    .em_rd_idx(em_rd), .em_we(em_we), .em_alu_res(em_alu),
    .mw_rd_idx(mw_rd), .mw_we(mw_we), .mw_wb_sel(wbs),
    .mw_alu_res(mw_alu), .mw_load_data(mw_ld), .mw_link_addr(mw_lk),
    .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b), .store_data(st)
  );

  function automatic logic [31:0] ref_wb(input logic [1:0] s, input logic [31:0] a,
                                         input logic [31:0] l, input logic [31:0] k);
    if (s == 2'b00) return a;
    if (s == 2'b01) return l;
    if (s == 2'b11) return k;
    return 32'h0;
  endfunction

  function automatic logic [1:0] ref_sel(input logic [4:0] src);
    bit e, m;
    e = em_we && (em_rd != 0) && (em_rd == src);
    m = mw_we && (mw_rd != 0) && (mw_rd == src);
    return e ? 2'b10 : (m ? 2'b01 : 2'b00);
  endfunction

  function automatic logic [31:0] ref_val(input logic [1:0] s, input logic [31:0] rf);
    case (s)
      2'b10:   return em_alu;
      2'b01:   return ref_wb(wbs, mw_alu, mw_ld, mw_lk);
      default: return rf;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [1:0] ea, eb;
    @(negedge clk);
    ea = ref_sel(rs1);
    eb = ref_sel(rs2);
    check(tag, "sel_a", {30'd0, sel_a}, {30'd0, ea});
    check(tag, "sel_b", {30'd0, sel_b}, {30'd0, eb});
    check(tag, "op_a", op_a, ref_val(ea, rfa));
    check(tag, "op_b", op_b, ref_val(eb, rfb));
    check("R8", "store_data", st, ref_val(eb, rfb));
  endtask

  task automatic setup(input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] er, input logic ew,
                       input logic [4:0] mr, input logic mwe, input logic [1:0] s);
    @(posedge clk);
    #1;
    rs1 = a; rs2 = b; em_rd = er; em_we = ew; mw_rd = mr; mw_we = mwe; wbs = s;
    rfa = $urandom; rfb = $urandom; em_alu = $urandom;
    mw_alu = $urandom; mw_ld = $urandom; mw_lk = $urandom;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rs1 = 0; rs2 = 0; em_rd = 0; mw_rd = 0; em_we = 0; mw_we = 0; wbs = 0;
    rfa = 32'h1111_1111; rfb = 32'h2222_2222; em_alu = 0; mw_alu = 0; mw_ld = 0; mw_lk = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    check_all("R1");                                 // quiescent state
    setup(5'd3, 5'd4, 5'd7, 1, 5'd8, 1, 2'b00); check_all("R1");
    setup(5'd3, 5'd4, 5'd3, 1, 5'd9, 1, 2'b00); check_all("R2");
    setup(5'd6, 5'd6, 5'd9, 1, 5'd6, 1, 2'b00); check_all("R3");
    setup(5'd5, 5'd5, 5'd5, 1, 5'd5, 1, 2'b01); check_all("R4");
    setup(5'd0, 5'd0, 5'd0, 1, 5'd0, 1, 2'b11); check_all("R5");
    setup(5'd2, 5'd2, 5'd2, 0, 5'd2, 0, 2'b00); check_all("R6");
    setup(5'd2, 5'd2, 5'd2, 0, 5'd2, 1, 2'b00); check_all("R6");
    setup(5'd7, 5'd1, 5'd0, 0, 5'd7, 1, 2'b00); check_all("R7");
    setup(5'd7, 5'd1, 5'd0, 0, 5'd7, 1, 2'b01); check_all("R7");
    setup(5'd7, 5'd1, 5'd0, 0, 5'd7, 1, 2'b11); check_all("R7");
    setup(5'd7, 5'd1, 5'd0, 0, 5'd7, 1, 2'b10); check_all("R7");
    setup(5'd1, 5'd2, 5'd1, 1, 5'd2, 1, 2'b11); check_all("R9");
    setup(5'd9, 5'd9, 5'd9, 1, 5'd1, 1, 2'b00); check_all("R8");
    for (int i = 0; i < 400; i++) begin
      setup(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)),
            1'($urandom), 2'($urandom));
      check_all("R9");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule